// File: doc/BRIEF.md
# GF(2^8) Sequential Field Inverter

This block returns the multiplicative inverse of one byte. Each byte is an element of GF(2^8) written in the polynomial basis, and the field polynomial is x^8+x^4+x^3+x^2+1. A nonzero element raised to 2^8-1 gives one, so its inverse is the element raised to 254.

The block builds that power with a fixed chain of eleven single-cycle operations. The chain makes 7 squarings and 4 multiplications. It shares one combinational multiplier and one squarer, and a small state machine steps both through three working registers: base, accumulator and saved term. Intermediate powers of 3, 7, 63 and 127 lead to the final squaring.

A client pulses `start` with the operand while the block is idle. It then waits for the one-cycle `done` pulse and reads `result`, which holds its value until the next computation finishes.

Top module: `gfinv_chain`

## Requirements
- R1: After reset `busy` and `done` are 0 and `result` is 8'h00.
- R2: For every nonzero operand the result r satisfies operand·r = 1 in GF(2^8). The product is taken modulo x^8+x^4+x^3+x^2+1, with bit i of a byte as the coefficient of x^i.
- R3: Operand 8'h00 gives result 8'h00.
- R4: `done` rises after the 13th rising edge, counting the edge that accepts `start` as the first. It stays high for exactly one cycle.
- R5: `busy` is high from the cycle after `start` is accepted through the `done` cycle inclusive, and low in every other cycle.
- R6: A `start` pulse or an operand change while `busy` is high is ignored. The current result is unaffected and no extra `done` pulse follows.
- R7: `result` keeps its value from one `done` pulse until the next, whatever the inputs do meanwhile.
- R8: Known pairs under this polynomial hold: 01↔01, 02↔8E, 03↔F4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an inversion; accepted only while idle |
| operand | input | 8 | Element to invert, sampled on the accepting edge |
| busy | output | 1 | Computation in progress, including the done cycle |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | 8 | Inverse of the last accepted operand |

## Verification
The zero operand is driven on purpose. A design that special-cased it wrongly, or had a chain bug that turned zero into one, would return a nonzero byte. Known pairs such as 02↔8E catch a wrong reduction polynomial. Those tables still contain a full set of inverse pairs, so only fixed vectors expose them. A sweep of all 256 operands checks the product against one, which finds a chain that reuses the wrong saved term or skips a squaring. Restarts during a run and operand changes after completion are also driven, to expose a controller that reloads its base mid-chain or lets the output follow the accumulator.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOAD,
      ST_RUN,
      ST_DONE
   } inv_state_e;

   typedef struct packed {
      logic sqr;        // 1: square the accumulator, 0: multiply
      logic use_keep;   // multiplier second operand: saved term instead of base
      logic save_keep;  // copy the new accumulator into the saved term
   } chain_op_t;

   localparam int CHAIN_STEPS = 11;

   // Power held after each step: 2,3,6,7,14,28,56,63,126,127,254
   function automatic chain_op_t chain_op(input logic [3:0] step);
      chain_op_t op;
      op = '{sqr: 1'b1, use_keep: 1'b0, save_keep: 1'b0};
      case (step)
         4'd1, 4'd9: op.sqr = 1'b0;
         4'd3: begin
            op.sqr       = 1'b0;
            op.save_keep = 1'b1;
         end
         4'd7: begin
            op.sqr      = 1'b0;
            op.use_keep = 1'b1;
         end
         default: ;
      endcase
      return op;
   endfunction

endpackage

// File: rtl/gf_reduce.sv
module gf_reduce #(
   parameter int          W    = 8,
   parameter logic [W-1:0] POLY = 8'h1D
) (
   input  logic [2*W-2:0] wide,
   output logic [W-1:0]   red
);
   localparam int          WW   = 2 * W - 1;
   localparam logic [W:0]  FULL = {1'b1, POLY};

   logic [WW-1:0] work;

   always_comb begin
      work = wide;
      for (int k = WW - 1; k >= W; k--) begin
         if (work[k]) work[k -: W+1] = work[k -: W+1] ^ FULL;
      end
      red = work[W-1:0];
   end
endmodule

// File: rtl/gf_mul.sv
module gf_mul #(
   parameter int          W    = 8,
   parameter logic [W-1:0] POLY = 8'h1D
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] p
);
   localparam int WW = 2 * W - 1;

   logic [WW-1:0] rows [W];
   logic [WW-1:0] prod;

   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_row
         assign rows[i] = b[i] ? ({{(W-1){1'b0}}, a} << i) : '0;
      end
   endgenerate

   always_comb begin
      prod = '0;
      for (int j = 0; j < W; j++) prod = prod ^ rows[j];
   end

   gf_reduce #(.W(W), .POLY(POLY)) u_red (.wide(prod), .red(p));

   always_comb begin
      p_unit_mul_r2: assert (b != W'(1) || p == a);
   end
endmodule

// File: rtl/gf_sqr.sv
module gf_sqr #(
   parameter int          W    = 8,
   parameter logic [W-1:0] POLY = 8'h1D
) (
   input  logic [W-1:0] a,
   output logic [W-1:0] s
);
   localparam int WW = 2 * W - 1;

   logic [WW-1:0] spread;

   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_even
         assign spread[2*i] = a[i];
      end
      for (i = 0; i < W - 1; i++) begin : g_odd
         assign spread[2*i+1] = 1'b0;
      end
   endgenerate

   gf_reduce #(.W(W), .POLY(POLY)) u_red (.wide(spread), .red(s));

   always_comb begin
      p_unit_sqr_r2: assert (a != W'(1) || s == W'(1));
   end
endmodule

// File: rtl/gf_chain_ctrl.sv
module gf_chain_ctrl
   import gfinv_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic accept,
   output logic load_acc,
   output logic step_en,
   output logic finish,
   output logic op_sqr,
   output logic op_keep,
   output logic op_save,
   output logic busy,
   output logic done
);
   localparam int          SW   = 4;
   localparam logic [SW-1:0] LAST = SW'(CHAIN_STEPS - 1);

   inv_state_e    state_q, state_d;
   logic [SW-1:0] step_q;
   chain_op_t     cur;

   assign cur      = chain_op(step_q);
   assign accept   = (state_q == ST_IDLE) && start;
   assign load_acc = (state_q == ST_LOAD);
   assign step_en  = (state_q == ST_RUN);
   assign finish   = step_en && (step_q == LAST);
   assign op_sqr   = cur.sqr;
   assign op_keep  = cur.use_keep;
   assign op_save  = step_en && cur.save_keep;
   assign busy     = (state_q != ST_IDLE);
   assign done     = (state_q == ST_DONE);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (start)  state_d = ST_LOAD;
         ST_LOAD:             state_d = ST_RUN;
         ST_RUN:  if (finish) state_d = ST_DONE;
         ST_DONE:             state_d = ST_IDLE;
         default:             state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
      end else begin
         state_q <= state_d;
         if (load_acc)     step_q <= '0;
         else if (step_en) step_q <= step_q + 1'b1;
      end
   end

   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_busy_on_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy);
   p_idle_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
endmodule

// File: rtl/gfinv_chain.sv
module gfinv_chain #(
   parameter int          WIDTH = 8,
   parameter logic [WIDTH-1:0] POLY = 8'h1D
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] operand,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] result
);
   import gfinv_pkg::*;

   localparam int LATENCY = CHAIN_STEPS + 2;

   generate
      if (WIDTH != 8) begin : g_bad_width
         $error("gfinv_chain: operation chain is fixed for 8-bit elements");
      end
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("gfinv_chain: field polynomial needs a constant term");
      end
   endgenerate

   logic accept, load_acc, step_en, finish, op_sqr, op_keep, op_save;
   logic [WIDTH-1:0] base_q, acc_q, keep_q, res_q;
   logic [WIDTH-1:0] mul_b, mul_out, sqr_out, acc_d;

   gf_chain_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .accept(accept), .load_acc(load_acc), .step_en(step_en),
      .finish(finish), .op_sqr(op_sqr), .op_keep(op_keep),
      .op_save(op_save), .busy(busy), .done(done)
   );

   assign mul_b = op_keep ? keep_q : base_q;
   assign acc_d = op_sqr ? sqr_out : mul_out;

   gf_mul #(.W(WIDTH), .POLY(POLY)) u_mul (.a(acc_q), .b(mul_b), .p(mul_out));
   gf_sqr #(.W(WIDTH), .POLY(POLY)) u_sqr (.a(acc_q), .s(sqr_out));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         acc_q  <= '0;
         keep_q <= '0;
         res_q  <= '0;
      end else begin
         if (accept)   base_q <= operand;
         if (load_acc) acc_q  <= base_q;
         else if (step_en) acc_q <= acc_d;
         if (op_save)  keep_q <= acc_d;
         if (finish)   res_q  <= acc_d;
      end
   end

   assign result = res_q;

   // latency tracker used only by the checks below
   logic [4:0] lat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_q <= '0;
      else if (accept) lat_q <= 5'd1;
      else if (busy)   lat_q <= lat_q + 1'b1;
   end

   p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> lat_q == 5'(LATENCY));
   p_zero_maps_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && base_q == '0) |-> result == '0);
   p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !finish |=> $stable(result));
   p_base_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(base_q));
endmodule

// File: tb/gfinv_chain_tb.sv
module gfinv_chain_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] operand = 8'h00;
   logic       busy, done;
   logic [7:0] result;

   int checks = 0;
   int errors = 0;
   logic [7:0] got;
   int lat;
   int busy_gaps;

   always #5 clk = ~clk;

   gfinv_chain u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
      .busy(busy), .done(done), .result(result)
   );

   localparam int NV = 6;
   localparam logic [15:0] VEC [NV] = '{
      16'h01_01, 16'h02_8E, 16'h03_F4, 16'h8E_02, 16'hF4_03, 16'h00_00
   };

   function automatic logic [7:0] ref_mul(input logic [7:0] x, input logic [7:0] y);
      logic [7:0] acc = 8'h00;
      logic [7:0] xx = x;
      logic [7:0] yy = y;
      for (int n = 0; n < 8; n++) begin
         if (yy[0]) acc = acc ^ xx;
         xx = {xx[6:0], 1'b0} ^ (xx[7] ? 8'h1D : 8'h00);
         yy = yy >> 1;
      end
      return acc;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [7:0] a);
      @(negedge clk);
      start = 1'b1;
      operand = a;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      busy_gaps = 0;
      while (!done && lat < 100) begin
         if (!busy) busy_gaps++;
         @(posedge clk);
         @(negedge clk);
         lat++;
      end
      if (!busy) busy_gaps++;
      got = result;
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(busy == 1'b0 && done == 1'b0 && result == 8'h00, "R1", {busy, done, result}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 / R3 known vectors
      for (int v = 0; v < NV; v++) begin
         run_op(VEC[v][15:8]);
         check(got == VEC[v][7:0], VEC[v][15:8] == 8'h00 ? "R3" : "R8", got, VEC[v][7:0]);
      end

      // R4 / R5 timing on one run
      run_op(8'h53);
      check(lat == 13, "R4", lat, 13);
      check(busy_gaps == 0, "R5", busy_gaps, 0);
      @(negedge clk);
      check(done == 1'b0, "R4", done, 0);
      check(busy == 1'b0, "R5", busy, 0);

      // R2 full sweep
      for (int x = 0; x < 256; x++) begin
         run_op(8'(x));
         if (x == 0) check(got == 8'h00, "R3", got, 0);
         else        check(ref_mul(8'(x), got) == 8'h01, "R2", ref_mul(8'(x), got), 1);
      end

      // R6 restart while busy is ignored
      @(negedge clk);
      start = 1'b1;
      operand = 8'h02;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      start = 1'b1;
      operand = 8'h03;
      @(negedge clk);
      start = 1'b0;
      operand = 8'hF4;
      while (!done) @(negedge clk);
      check(result == 8'h8E, "R6", result, 8'h8E);
      begin
         int extra = 0;
         for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (done) extra++;
         end
         check(extra == 0, "R6", extra, 0);
      end

      // R7 result held while inputs wander
      operand = 8'h77;
      repeat (5) @(negedge clk);
      check(result == 8'h8E, "R7", result, 8'h8E);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule